// File: doc/BRIEF.md
# Soft-Bit Credit Gate

This block sits between a one-sample-per-clock symbol demapper and the rate de-matching stage that follows it. Each valid complex sample from the demapper adds to a single running soft-bit total. The amount added depends on the modulation order of the current user. The downstream stage posts a request that carries the number of soft bits it needs for its next block. The gate holds that request until the running total covers it. It then emits a one-cycle start and subtracts the requested amount from the total.

A synchronous clear opens a new user. It zeroes the total, drops any pending request and loads the user's resource-block count. The expected sample total for the user is that count times 12 subcarriers times the symbols per TTI. A done flag rises once that many samples have been taken in. Samples that arrive after that point are not counted.

Top module: `softbit_gate`

## Requirements
- R1: While `rst_ni` is low and after reset, `count_o` is 0 and `start_o` is 0. No request is pending. The sample total is 0, so `done_o` reads 1 until the first clear.
- R2: Each cycle with `smp_valid_i` high and `done_o` low adds soft bits to the total according to `mod_i`: 2'b00 adds 2 (QPSK), 2'b01 adds 4 (16QAM), 2'b10 adds 6 (64QAM) and 2'b11 adds 0. The new total shows on `count_o` one cycle later.
- R3: A sample presented while `done_o` is high changes neither `count_o` nor the sample progress.
- R4: When a request is pending and `count_o` is at least its bit count at a clock edge, `start_o` is high for exactly that following cycle. `start_o` is never high two cycles in a row.
- R5: On the edge that raises `start_o`, the requested bit count is subtracted from the total. A sample taken on the same edge is added as well, so the new total is old + sample bits - request.
- R6: `req_valid_i` loads `req_bits_i` (40 to 6144) as the pending request only when no request is pending. While one is pending, a new request is ignored.
- R7: `done_o` is high exactly when the number of samples taken since the last clear equals `rb_num_i` (sampled at that clear) × 12 × `SYM_PER_TTI`.
- R8: `clr_i` takes priority over everything else. On the next cycle the total is 0, no request is pending, no start is issued, and the sample progress restarts for the new resource-block count.
- R9: `count_o` never exceeds `MAX_RB` × 12 × `SYM_PER_TTI` × 6, so the total cannot wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous start of a new user |
| rb_num_i | input | RB_W | Resource blocks of the new user, sampled on clr_i |
| smp_valid_i | input | 1 | One demapped complex sample this cycle |
| mod_i | input | 2 | Modulation code of the current sample |
| req_valid_i | input | 1 | Downstream posts a request |
| req_bits_i | input | REQ_W | Soft bits the request needs |
| start_o | output | 1 | One-cycle start to the downstream stage |
| count_o | output | CNT_W | Current soft-bit total |
| done_o | output | 1 | All samples of the current user taken |

## Verification
On every cycle, the assertions check these behaviours:
- `start_o` is a single-cycle pulse.
- A start only follows a total that covered the pending request.
- A clear zeroes the total.
- The total never rises by more than six bits per cycle and never exceeds its bound.
- `done_o` holds until the next clear.

The remaining behaviours need the bench's scenarios to show them:
- The per-code bit weights.
- The exact result when a deduction and an increment share an edge.
- Ignoring a second request while one is pending.
- Dropping a pending request on clear.
- The exact sample on which `done_o` rises.

// File: rtl/softbit_pkg.sv
package softbit_pkg;
  localparam int SC_PER_RB = 12;
  localparam int MAX_QM    = 6;
  localparam int REQ_W     = 13;

  typedef enum logic [1:0] {
    MOD_QPSK  = 2'b00,
    MOD_QAM16 = 2'b01,
    MOD_QAM64 = 2'b10,
    MOD_NONE  = 2'b11
  } mod_e;
endpackage

// File: rtl/softbit_qm.sv
module softbit_qm
  import softbit_pkg::*;
(
  input  logic [1:0] mod_i,
  output logic [2:0] qm_o
);
  always_comb begin
    unique case (mod_e'(mod_i))
      MOD_QPSK:  qm_o = 3'd2;
      MOD_QAM16: qm_o = 3'd4;
      MOD_QAM64: qm_o = 3'd6;
      default:   qm_o = 3'd0;
    endcase
  end
endmodule

// File: rtl/softbit_progress.sv
module softbit_progress #(
  parameter int RB_W  = 7,
  parameter int SMP_W = 14,
  parameter int SYM   = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [RB_W-1:0]  rb_num_i,
  input  logic             smp_valid_i,
  output logic             take_o,
  output logic             done_o
);
  localparam int PER_RB = softbit_pkg::SC_PER_RB * SYM;

  logic [SMP_W-1:0] smp_q, tot_q;

  assign done_o = (smp_q == tot_q);
  assign take_o = smp_valid_i && !done_o && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q <= '0;
      tot_q <= '0;
    end else if (clr_i) begin
      smp_q <= '0;
      tot_q <= SMP_W'(rb_num_i * PER_RB);
    end else if (take_o) begin
      smp_q <= smp_q + 1'b1;
    end
  end
endmodule

// File: rtl/softbit_credit.sv
module softbit_credit #(
  parameter int CNT_W = 17,
  parameter int REQ_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             take_i,
  input  logic [2:0]       qm_i,
  input  logic             req_valid_i,
  input  logic [REQ_W-1:0] req_bits_i,
  output logic             start_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pend_o,
  output logic [REQ_W-1:0] req_o
);
  logic [CNT_W-1:0] cnt_q, add_w, sub_w;
  logic             pend_q, fire_w;
  logic [REQ_W-1:0] req_q;

  assign fire_w = pend_q && (cnt_q >= CNT_W'(req_q));
  assign add_w  = take_i ? CNT_W'(qm_i) : '0;
  assign sub_w  = fire_w ? CNT_W'(req_q) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      req_q   <= '0;
      start_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      start_o <= 1'b0;
    end else begin
      cnt_q   <= cnt_q + add_w - sub_w;
      start_o <= fire_w;
      if (fire_w) begin
        pend_q <= 1'b0;
      end else if (req_valid_i && !pend_q) begin
        pend_q <= 1'b1;
        req_q  <= req_bits_i;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign pend_o = pend_q;
  assign req_o  = req_q;
endmodule

// File: rtl/softbit_gate.sv
module softbit_gate
  import softbit_pkg::*;
#(
  parameter int MAX_RB      = 100,
  parameter int SYM_PER_TTI = 12,
  localparam int MAX_SMP    = MAX_RB * SC_PER_RB * SYM_PER_TTI,
  localparam int MAX_BITS   = MAX_SMP * MAX_QM,
  localparam int RB_W       = $clog2(MAX_RB + 1),
  localparam int SMP_W      = $clog2(MAX_SMP + 1),
  localparam int CNT_W      = $clog2(MAX_BITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [RB_W-1:0]  rb_num_i,
  input  logic             smp_valid_i,
  input  logic [1:0]       mod_i,
  input  logic             req_valid_i,
  input  logic [REQ_W-1:0] req_bits_i,
  output logic             start_o,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o
);
  logic       take_w;
  logic [2:0] qm_w;
  logic       pend_w;
  logic [REQ_W-1:0] req_w;

  softbit_qm u_qm (
    .mod_i (mod_i),
    .qm_o  (qm_w)
  );

  softbit_progress #(
    .RB_W  (RB_W),
    .SMP_W (SMP_W),
    .SYM   (SYM_PER_TTI)
  ) u_progress (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr_i),
    .rb_num_i    (rb_num_i),
    .smp_valid_i (smp_valid_i),
    .take_o      (take_w),
    .done_o      (done_o)
  );

  softbit_credit #(
    .CNT_W (CNT_W),
    .REQ_W (REQ_W)
  ) u_credit (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr_i),
    .take_i      (take_w),
    .qm_i        (qm_w),
    .req_valid_i (req_valid_i),
    .req_bits_i  (req_bits_i),
    .start_o     (start_o),
    .cnt_o       (count_o),
    .pend_o      (pend_w),
    .req_o       (req_w)
  );
endmodule

// File: rtl/softbit_gate_chk.sv
module softbit_gate_chk #(
  parameter int CNT_W    = 17,
  parameter int REQ_W    = 13,
  parameter int MAX_BITS = 86400
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             start_o,
  input logic [CNT_W-1:0] count_o,
  input logic             done_o,
  input logic [REQ_W-1:0] req_w
);
  always_comb begin
    if (!rst_ni) a_reset_r1: assert (count_o == '0 && !start_o);
  end

  p_single_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  p_start_covered_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_o) |-> ($past(count_o) >= CNT_W'($past(req_w))));

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (count_o == '0 && !start_o));

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ({1'b0, count_o} <= {1'b0, $past(count_o)} + 6));

  p_done_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clr_i) |=> done_o);

  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(count_o) <= MAX_BITS);
endmodule

bind softbit_gate softbit_gate_chk #(
  .CNT_W    (CNT_W),
  .REQ_W    (softbit_pkg::REQ_W),
  .MAX_BITS (MAX_BITS)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clr_i   (clr_i),
  .start_o (start_o),
  .count_o (count_o),
  .done_o  (done_o),
  .req_w   (req_w)
);

// File: tb/softbit_gate_bench.sv
module softbit_gate_bench;
  localparam int RB_W  = 7;
  localparam int CNT_W = 17;
  localparam int REQ_W = 13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic clr = 1'b0, sv = 1'b0, rv = 1'b0;
  logic [RB_W-1:0]  rb = '0;
  logic [1:0]       md = '0;
  logic [REQ_W-1:0] rbits = '0;
  logic             start, done;
  logic [CNT_W-1:0] count;

  int checks = 0, errors = 0, n_start = 0;

  always #4 clk = ~clk;

  softbit_gate u_softbit_gate (
    .clk_i (clk), .rst_ni (rst_n), .clr_i (clr), .rb_num_i (rb),
    .smp_valid_i (sv), .mod_i (md), .req_valid_i (rv), .req_bits_i (rbits),
    .start_o (start), .count_o (count), .done_o (done)
  );

  // reference model from the requirements
  int m_cnt = 0, m_req = 0, m_smp = 0, m_tot = 0;
  bit m_pend = 0, m_start = 0;
  int q_exp[$];

  function automatic int qm_of(logic [1:0] c);
    case (c)
      2'b00: return 2;
      2'b01: return 4;
      2'b10: return 6;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      if (clr) begin
        m_cnt = 0; m_pend = 0; m_smp = 0; m_tot = rb * 144; m_start = 0;
      end else begin
        bit fire;
        int inc;
        fire = m_pend && (m_cnt >= m_req);
        inc  = (sv && m_smp != m_tot) ? qm_of(md) : 0;
        if (sv && m_smp != m_tot) m_smp++;
        m_cnt = m_cnt + inc - (fire ? m_req : 0);
        m_start = fire;
        if (fire) begin
          m_pend = 0;
          q_exp.push_back(m_cnt);
        end else if (rv && !m_pend) begin
          m_pend = 1; m_req = rbits;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (start) begin
        n_start++;
        if (q_exp.size() == 0) chk(0, "R4 unexpected start", 1, 0);
        else begin
          int e;
          e = q_exp.pop_front();
          chk(count == CNT_W'(e), "R5 count after start", count, e);
        end
      end else if (m_start) chk(0, "R4 missed start", 0, 1);
      chk(count == CNT_W'(m_cnt), "R5 running total", count, m_cnt);
      chk(done == (m_smp == m_tot), "R7 done flag", done, m_smp == m_tot);
    end
  end

  task automatic samples(input int n, input logic [1:0] c);
    for (int i = 0; i < n; i++) begin
      sv = 1'b1; md = c;
      @(negedge clk);
    end
    sv = 1'b0;
  endtask

  task automatic request(input int b);
    rv = 1'b1; rbits = REQ_W'(b);
    @(negedge clk);
    rv = 1'b0;
  endtask

  task automatic user(input int r);
    clr = 1'b1; rb = RB_W'(r);
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    chk(count == 0 && start == 0, "R1 reset outputs", count, 0);
    chk(done == 1, "R1 done with no user", done, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(count == 0, "R1 after release", count, 0);

    user(1);
    chk(done == 0 && count == 0, "R8 new user", count, 0);
    samples(10, 2'b00);
    @(negedge clk);
    chk(count == 20, "R2 QPSK weight", count, 20);
    samples(3, 2'b11);
    @(negedge clk);
    chk(count == 20, "R2 code 11 adds none", count, 20);
    samples(5, 2'b01);
    @(negedge clk);
    chk(count == 40, "R2 16QAM weight", count, 40);
    samples(2, 2'b10);
    @(negedge clk);
    chk(count == 52, "R2 64QAM weight", count, 52);

    s0 = n_start;
    request(40);
    repeat (3) @(negedge clk);
    chk(n_start == s0 + 1, "R4 one start", n_start - s0, 1);
    chk(count == 12, "R5 deduction", count, 12);

    s0 = n_start;
    request(100);
    request(10);
    samples(20, 2'b10);
    repeat (3) @(negedge clk);
    chk(count == 32, "R6 second request ignored", count, 32);
    chk(n_start == s0 + 1, "R6 single start", n_start - s0, 1);

    samples(103, 2'b00);
    @(negedge clk);
    chk(done == 0, "R7 not done at 143", done, 0);
    samples(1, 2'b00);
    @(negedge clk);
    chk(done == 1, "R7 done at 144", done, 1);
    chk(count == 240, "R7 total at completion", count, 240);
    samples(5, 2'b10);
    @(negedge clk);
    chk(count == 240, "R3 late samples ignored", count, 240);

    s0 = n_start;
    request(1000);
    user(2);
    chk(count == 0 && done == 0, "R8 clear", count, 0);
    samples(10, 2'b10);
    request(40);
    repeat (3) @(negedge clk);
    chk(n_start == s0 + 1 && count == 20, "R8 pending dropped", count, 20);

    user(10);
    s0 = n_start;
    request(6144);
    samples(1100, 2'b10);
    repeat (2) @(negedge clk);
    chk(count == 456, "R9 large request", count, 456);
    chk(n_start == s0 + 1, "R4 large start", n_start - s0, 1);
    chk(count <= 86400, "R9 bound", count, 86400);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule